// File: doc/BRIEF.md
# Write Byte-Merge Buffer

This block sits between a host-side request stream and a 32-bit memory master port. Host memory writes of a byte or a halfword that land in the same aligned DWORD are folded into one pending entry. That entry goes out later as a single 32-bit data phase whose byte enables are the union of the enables of the writes that built it. Folding happens only when merging is switched on and the address falls inside a programmable prefetchable window. The window is defined by a base and a mask: an address qualifies when `(addr & mask) == base`.

Every other request leaves in arrival order with the enables it came with. This covers writes outside the window, all writes while merging is off, and all reads. Before such a request goes out, the pending entry is pushed to the master port, so a target that has side effects sees the program order. The same push happens for a write to a new DWORD. An idle counter also pushes the entry once the host has been quiet for a configured number of cycles.

Both sides use valid/ready handshakes. The downstream side has one output register. The host sees ready drop whenever its request needs that register and the register is still waiting on the master port.

Top module: `wmerge_buf`

## Requirements
- R1: After reset, `dn_valid` is low and stays low until a request is accepted.
- R2: With merging on, in-window writes to the same DWORD produce one write phase. Its `dn_be` is the OR of their enables. For each lane, the data is the byte from the latest write that enabled that lane.
- R3: An in-window write to a different DWORD sends out the pending entry first. The new write then becomes the pending entry, so phases keep arrival order.
- R4: A write outside the window is never merged. It leaves as its own phase with its own `up_be` and data, after any pending entry.
- R5: With `cfg_merge_en` low, every write leaves as its own phase with its original enables.
- R6: A read is issued only after any pending entry has gone out. It appears with `dn_write` low and its own `up_be`.
- R7: An address is in the window exactly when `(up_addr & cfg_win_mask) == cfg_win_base`.
- R8: A pending entry with no host request in progress goes out after `cfg_idle_limit`+1 idle cycles. `dn_valid` rises after the (`cfg_idle_limit`+1)-th clock edge that follows acceptance.
- R9: While `dn_valid` is high and `dn_ready` is low, all `dn_*` outputs hold their values.
- R10: `up_ready` is low while the accepted request would need the output register and that register is stalled.
- R11: `dn_addr` is always DWORD-aligned, with bits [1:0] equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_merge_en | input | 1 | Enables write merging |
| cfg_win_base | input | AW | Prefetchable window base |
| cfg_win_mask | input | AW | Prefetchable window mask |
| cfg_idle_limit | input | IDLE_W | Idle cycles before a pending entry is pushed |
| up_valid | input | 1 | Host request valid |
| up_ready | output | 1 | Host request accepted |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | AW | Host byte address |
| up_wdata | input | 32 | Host write data, lane positioned |
| up_be | input | 4 | Host byte enables, bit i = lane i |
| dn_valid | output | 1 | Master request valid |
| dn_ready | input | 1 | Master request taken |
| dn_write | output | 1 | 1 = write, 0 = read |
| dn_addr | output | AW | DWORD-aligned address |
| dn_wdata | output | 32 | Data phase |
| dn_be | output | 4 | Byte enables of the data phase |

## Verification
The case that is hardest to reach is a stalled master port while a pending entry and a queued phase both exist. Only then does the host see ready fall, and only then must the output freeze. The bench gets there by holding `dn_ready` low and sending two writes to different DWORDs. The first write fills the pending entry, and the second moves it into the output register. A third request then finds both slots occupied, and the bench checks ready and output stability before releasing the port. Every pair of enable patterns, all sixteen window pages under two masks, and a range of idle limits are swept.

// File: rtl/wmerge_buf.sv
module wmerge_buf #(
  parameter int AW     = 32,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_merge_en,
  input  logic [AW-1:0]     cfg_win_base,
  input  logic [AW-1:0]     cfg_win_mask,
  input  logic [IDLE_W-1:0] cfg_idle_limit,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_write,
  input  logic [AW-1:0]     up_addr,
  input  logic [31:0]       up_wdata,
  input  logic [3:0]        up_be,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [AW-1:0]     dn_addr,
  output logic [31:0]       dn_wdata,
  output logic [3:0]        dn_be
);

  localparam logic [IDLE_W-1:0] IDLE_MAX = '1;

  logic              pend_v;
  logic [AW-1:0]     pend_addr;
  logic [31:0]       pend_data;
  logic [3:0]        pend_be;
  logic [IDLE_W-1:0] idle_cnt;

  logic [AW-1:0] req_dw;
  logic in_win, mergeable, hit, out_free, timed_out;
  logic take, new_pend, merge_now, flush, fwd;

  assign req_dw    = {up_addr[AW-1:2], 2'b00};
  assign in_win    = (up_addr & cfg_win_mask) == cfg_win_base;
  assign mergeable = up_write && cfg_merge_en && in_win;
  assign hit       = pend_v && mergeable && (pend_addr == req_dw);
  assign out_free  = !dn_valid || dn_ready;
  assign timed_out = pend_v && !up_valid && (idle_cnt >= cfg_idle_limit);
  assign up_ready  = take;

  always_comb begin
    take = 1'b0; new_pend = 1'b0; merge_now = 1'b0; flush = 1'b0; fwd = 1'b0;
    if (up_valid) begin
      if (hit) begin
        take = 1'b1; merge_now = 1'b1;
      end else if (mergeable) begin
        if (!pend_v) begin
          take = 1'b1; new_pend = 1'b1;
        end else if (out_free) begin
          take = 1'b1; new_pend = 1'b1; flush = 1'b1;
        end
      end else if (pend_v) begin
        flush = out_free;
      end else if (out_free) begin
        take = 1'b1; fwd = 1'b1;
      end
    end else if (timed_out && out_free) begin
      flush = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      pend_be   <= '0;
    end else if (new_pend) begin
      pend_v    <= 1'b1;
      pend_addr <= req_dw;
      pend_data <= up_wdata;
      pend_be   <= up_be;
    end else if (merge_now) begin
      for (int i = 0; i < 4; i++)
        if (up_be[i]) pend_data[8*i +: 8] <= up_wdata[8*i +: 8];
      pend_be <= pend_be | up_be;
    end else if (flush) begin
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || new_pend || merge_now || up_valid)
      idle_cnt <= '0;
    else if (pend_v && idle_cnt != IDLE_MAX)
      idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_write <= 1'b0;
      dn_addr  <= '0;
      dn_wdata <= '0;
      dn_be    <= '0;
    end else if (flush) begin
      dn_valid <= 1'b1;
      dn_write <= 1'b1;
      dn_addr  <= pend_addr;
      dn_wdata <= pend_data;
      dn_be    <= pend_be;
    end else if (fwd) begin
      dn_valid <= 1'b1;
      dn_write <= up_write;
      dn_addr  <= req_dw;
      dn_wdata <= up_wdata;
      dn_be    <= up_be;
    end else if (dn_ready) begin
      dn_valid <= 1'b0;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_wdata)
                              && $stable(dn_be) && $stable(dn_write));

  p_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> dn_addr[1:0] == 2'b00);

  p_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready && up_write && !in_win
      |=> dn_valid && dn_write && dn_be == $past(up_be) && dn_wdata == $past(up_wdata));

  p_nomerge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready && up_write && !cfg_merge_en
      |=> dn_valid && dn_be == $past(up_be) && dn_addr == $past(req_dw));

  p_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready && !up_write |=> dn_valid && !dn_write && dn_be == $past(up_be));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && !mergeable && dn_valid && !dn_ready |-> !up_ready);

endmodule

// File: tb/wmerge_buf_test.sv
module wmerge_buf_test;
  logic clk = 0, rst_n = 0;
  logic cfg_merge_en = 1;
  logic [31:0] cfg_win_base = 32'h1000, cfg_win_mask = 32'hFFFF_F000;
  logic [7:0] cfg_idle_limit = 8'd200;
  logic up_valid = 0, up_write = 0, dn_ready = 1;
  logic [31:0] up_addr = 0, up_wdata = 0;
  logic [3:0] up_be = 0;
  logic up_ready, dn_valid, dn_write;
  logic [31:0] dn_addr, dn_wdata;
  logic [3:0] dn_be;
  int checks = 0, errs = 0;
  logic [68:0] mq[$];

  always #10 clk = ~clk;

  wmerge_buf #(.AW(32), .IDLE_W(8)) uut (.*);

  always begin
    @(negedge clk); #5;
    if (rst_n && dn_valid && dn_ready) mq.push_back({dn_write, dn_addr, dn_wdata, dn_be});
  end

  function automatic logic [31:0] lm(input logic [3:0] b);
    return {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
  endfunction

  task automatic chk(input string r, input logic [68:0] got, input logic [68:0] exp);
    checks++;
    if (got !== exp) begin errs++; $display("FAIL %s got=%h exp=%h", r, got, exp); end
  endtask

  task automatic chk_n(input string r, input int got, input int exp);
    checks++;
    if (got != exp) begin errs++; $display("FAIL %s got=%0d exp=%0d", r, got, exp); end
  endtask

  task automatic entry(input string r, input int i, input logic w, input logic [31:0] a,
                       input logic [31:0] d, input logic [3:0] b);
    logic [68:0] g;
    g = (i < mq.size()) ? mq[i] : '0;
    g[35:4] = g[35:4] & lm(b);
    chk(r, g, {w, a, d & lm(b), b});
  endtask

  task automatic send(input logic w, input logic [31:0] a, input logic [31:0] d, input logic [3:0] b);
    up_valid = 1; up_write = w; up_addr = a; up_wdata = d; up_be = b;
    #1;
    while (!up_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    up_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(3);
    chk_n("R1 dn_valid after reset", int'(dn_valid), 0);
    chk_n("R1 no output after reset", mq.size(), 0);

    // R2: every pair of enable patterns merged in one DWORD
    for (int b1 = 1; b1 < 16; b1++)
      for (int b2 = 1; b2 < 16; b2++) begin
        logic [31:0] d1, d2, e;
        d1 = {4{b1[3:0], 4'h1}}; d2 = {4{b2[3:0], 4'h2}};
        for (int i = 0; i < 4; i++) e[8*i +: 8] = b2[i] ? d2[8*i +: 8] : d1[8*i +: 8];
        mq.delete();
        send(1, 32'h1011, d1, b1[3:0]);
        send(1, 32'h1013, d2, b2[3:0]);
        send(0, 32'h1010, 0, 4'hF);
        idle(5);
        chk_n("R2 phase count", mq.size(), 2);
        entry("R2 merged phase", 0, 1, 32'h1010, e, b1[3:0] | b2[3:0]);
        entry("R6 read after flush", 1, 0, 32'h1010, 0, 4'hF);
      end

    // R3: DWORD change flushes in order
    mq.delete();
    send(1, 32'h1000, 32'h11, 4'h1);
    send(1, 32'h1004, 32'h2200, 4'h2);
    send(1, 32'h1009, 32'h330000, 4'h4);
    send(0, 32'h1000, 0, 4'h3);
    idle(6);
    chk_n("R3 count", mq.size(), 4);
    entry("R3 first", 0, 1, 32'h1000, 32'h11, 4'h1);
    entry("R3 second", 1, 1, 32'h1004, 32'h2200, 4'h2);
    entry("R3 third", 2, 1, 32'h1008, 32'h330000, 4'h4);
    entry("R6 read last", 3, 0, 32'h1000, 0, 4'h3);

    // R4: outside writes unmerged, after pending
    mq.delete();
    send(1, 32'h1020, 32'hAA, 4'h1);
    send(1, 32'h2021, 32'hBB00, 4'h2);
    send(1, 32'h2022, 32'hCC0000, 4'h4);
    idle(6);
    chk_n("R4 count", mq.size(), 3);
    entry("R4 pending first", 0, 1, 32'h1020, 32'hAA, 4'h1);
    entry("R4 own phase a", 1, 1, 32'h2020, 32'hBB00, 4'h2);
    entry("R4 own phase b", 2, 1, 32'h2020, 32'hCC0000, 4'h4);

    // R7: window sweep under two masks
    for (int c = 0; c < 2; c++) begin
      cfg_win_base = c == 0 ? 32'h1000 : 32'h2000;
      cfg_win_mask = c == 0 ? 32'hFFFF_F000 : 32'hFFFF_E000;
      for (int k = 0; k < 16; k++) begin
        bit w;
        w = (c == 0) ? (k == 1) : (k == 2 || k == 3);
        mq.delete();
        send(1, (k << 12) | 32'h40, 32'h5, 4'h1);
        send(1, (k << 12) | 32'h42, 32'h60000, 4'h4);
        send(0, (k << 12) | 32'h40, 0, 4'hF);
        idle(5);
        chk_n("R7 window decides merge", mq.size(), w ? 2 : 3);
        entry("R7 first phase", 0, 1, (k << 12) | 32'h40, w ? 32'h60005 : 32'h5, w ? 4'h5 : 4'h1);
      end
    end
    cfg_win_base = 32'h1000; cfg_win_mask = 32'hFFFF_F000;

    // R5: merging disabled
    cfg_merge_en = 0;
    mq.delete();
    send(1, 32'h1050, 32'h7, 4'h1);
    send(1, 32'h1051, 32'h800, 4'h2);
    idle(5);
    chk_n("R5 count", mq.size(), 2);
    entry("R5 first", 0, 1, 32'h1050, 32'h7, 4'h1);
    entry("R5 second", 1, 1, 32'h1050, 32'h800, 4'h2);
    cfg_merge_en = 1;

    // R6: lone read
    mq.delete();
    send(0, 32'h1062, 0, 4'h4);
    idle(4);
    chk_n("R6 lone read count", mq.size(), 1);
    entry("R6 lone read", 0, 0, 32'h1060, 0, 4'h4);

    // R8: idle timeout sweep
    for (int li = 0; li < 6; li++) begin
      int lim, first;
      lim = (li < 5) ? li : 9;
      cfg_idle_limit = lim[7:0];
      first = -1;
      send(1, 32'h1030, 32'h9, 4'h1);
      for (int n = 1; n < lim + 4; n++) begin
        @(negedge clk); #6;
        if (dn_valid && first < 0) first = n;
      end
      chk_n("R8 timeout edge", first, lim + 1);
      idle(2);
      mq.delete();
    end
    cfg_idle_limit = 8'd200;

    // R9 / R10: back-pressure
    mq.delete();
    dn_ready = 0;
    send(1, 32'h1000, 32'h1, 4'h1);
    send(1, 32'h1004, 32'h200, 4'h2);
    up_valid = 1; up_write = 1; up_addr = 32'h1008; up_wdata = 32'h30000; up_be = 4'h4;
    #1;
    chk_n("R10 ready low when stalled", int'(up_ready), 0);
    idle(3); #1;
    chk_n("R10 still low", int'(up_ready), 0);
    chk("R9 held output", {dn_valid, dn_write, dn_addr, dn_be}, {1'b1, 1'b1, 32'h1000, 4'h1});
    dn_ready = 1;
    #1;
    while (!up_ready) begin @(negedge clk); #1; end
    @(negedge clk); up_valid = 0;
    send(0, 32'h1000, 0, 4'hF);
    idle(6);
    chk_n("R9 count", mq.size(), 4);
    entry("R9 a", 0, 1, 32'h1000, 32'h1, 4'h1);
    entry("R9 b", 1, 1, 32'h1004, 32'h200, 4'h2);
    entry("R11 aligned c", 2, 1, 32'h1008, 32'h30000, 4'h4);
    entry("R6 read end", 3, 0, 32'h1000, 0, 4'hF);

    summary();
    $finish;
  end
endmodule